// File: doc/BRIEF.md
# Peripheral Base Address Decoder

This block turns the configuration bytes of an I/O controller into decoded I/O base addresses for four peripherals: a floppy disk controller, a parallel port and two serial ports. Each base byte is masked, shifted into a 12-bit address and aligned to its port's granularity. The result is checked against a legal window. A value outside that window is replaced by the port's conventional legacy address.

The parallel port also reacts to its mode bits. When the extended-mode gate is on, enhanced-parallel mode widens the decode window from four to eight ports. Extended-capabilities mode moves a second register bank up by setting address bit 10. Per-port enables combine the top two bits of each base byte with power-down bits from a shared control byte. All results are held in an output register and appear one clock after the inputs. The reset is asynchronous active-low and is released synchronously inside the block.

Top module: `periph_base_decoder`

## Requirements
- R1: The floppy base is `{fdc_cfg_i & 0xFC, 2'b00}` in 12 bits, masked with 0xFF0, so bits [3:0] are always zero.
- R2: When the R1 result is below 0x100 or above 0x3F0, the floppy base is 0x3F0.
- R3: Each serial base is `{cfg & 0xFE, 2'b00}` masked with 0xFF8. A result outside 0x100..0x3F8 becomes 0x3F8 for serial port 0 and 0x2F8 for serial port 1.
- R4: The parallel base is `{par_cfg_i, 2'b00}`. It is masked with 0x3F8 in enhanced-parallel mode and with 0x3FC otherwise, and `par_win_o` reports 8 or 4 ports to match.
- R5: When the aligned parallel base is below 0x100 or above 0x3FF, it becomes 0x378.
- R6: Enhanced-parallel mode is `ext_cfg_i[7] & mode_cfg_i[2]`. Extended-capabilities mode is `ext_cfg_i[7] & mode_cfg_i[3]`. When `ext_cfg_i[7]` is 0, both mode bits have no effect.
- R7: In extended-capabilities mode, bit 10 of the parallel base is set on top of the R4/R5 result, including the fallback value. Otherwise bit 10 is clear.
- R8: A port is enabled only when bit 7 or bit 6 of its own base byte is set.
- R9: The parallel port, serial port 0 and serial port 1 are additionally disabled by `pd_cfg_i` bit 7, bit 5 and bit 4 respectively. The other bits of `pd_cfg_i` have no effect, and the floppy enable ignores `pd_cfg_i`.
- R10: Every output reflects the inputs sampled at the previous rising clock edge, exactly one cycle later.
- R11: While reset is asserted, the outputs are: floppy 0x3F0, parallel 0x378, serial 0x3F8 and 0x2F8, window 4, and all enables 0. Assertion of reset acts at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fdc_cfg_i | input | 8 | Floppy base byte |
| par_cfg_i | input | 8 | Parallel base byte |
| ser0_cfg_i | input | 8 | Serial port 0 base byte |
| ser1_cfg_i | input | 8 | Serial port 1 base byte |
| pd_cfg_i | input | 8 | Power-down byte (bits 7, 5, 4) |
| mode_cfg_i | input | 8 | Parallel mode byte (bit 2 enhanced, bit 3 extended) |
| ext_cfg_i | input | 8 | Extended-mode gate byte (bit 7) |
| fdc_base_o | output | 12 | Floppy base address |
| fdc_en_o | output | 1 | Floppy enable |
| par_base_o | output | 12 | Parallel base address |
| par_win_o | output | 4 | Parallel decode window in ports (4 or 8) |
| par_en_o | output | 1 | Parallel enable |
| ser0_base_o | output | 12 | Serial port 0 base address |
| ser0_en_o | output | 1 | Serial port 0 enable |
| ser1_base_o | output | 12 | Serial port 1 base address |
| ser1_en_o | output | 1 | Serial port 1 enable |

## Verification
The bench builds the block with its default parameters: a 12-bit address, legal floor 0x100, and the legacy fallbacks 0x3F0, 0x378, 0x3F8 and 0x2F8. With 8-bit base bytes these settings let both edges of every legal window be reached. The bench drives bytes that land exactly on the floor and ceiling, and bytes just below the floor. It also drives the parallel byte 0xFF, whose 0x3FC result separates the 4-port and 8-port alignments. The extended-capabilities fallback 0x778 is exercised as well, together with each power-down bit on its own and with the ignored bit 6.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int unsigned PBD_AW = 12;
  localparam int unsigned PBD_CW = 8;

  typedef logic [PBD_AW-1:0] io_addr_t;

  typedef struct packed {
    io_addr_t base;
    logic     en;
  } slot_t;
endpackage

// File: rtl/pbd_rst_sync.sv
module pbd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/pbd_slot_calc.sv
module pbd_slot_calc
  import pbd_pkg::*;
#(
  parameter logic [PBD_CW-1:0] KEEP  = 8'hFC,
  parameter int unsigned       SHIFT = 2,
  parameter io_addr_t          ALIGN = 12'hFF0,
  parameter io_addr_t          LO    = 12'h100,
  parameter io_addr_t          HI    = 12'h3F0,
  parameter io_addr_t          DEF   = 12'h3F0
) (
  input  logic [PBD_CW-1:0] cfg_i,
  input  logic              pd_i,
  output slot_t             slot_o
);
  io_addr_t wide;
  io_addr_t aligned;
  logic     out_of_range;
  logic     unused_low_bits;

  assign unused_low_bits = ^(cfg_i & ~KEEP);

  always_comb begin
    wide         = PBD_AW'(cfg_i & KEEP) << SHIFT;
    aligned      = wide & ALIGN;
    out_of_range = (aligned < LO) || (aligned > HI);
    slot_o.base  = out_of_range ? DEF : aligned;
    slot_o.en    = (|cfg_i[PBD_CW-1 -: 2]) & ~pd_i;
  end
endmodule

// File: rtl/pbd_par_calc.sv
module pbd_par_calc
  import pbd_pkg::*;
#(
  parameter int unsigned SHIFT   = 2,
  parameter io_addr_t    ALIGN_W = 12'h3F8,
  parameter io_addr_t    ALIGN_N = 12'h3FC,
  parameter io_addr_t    LO      = 12'h100,
  parameter io_addr_t    HI      = 12'h3FF,
  parameter io_addr_t    DEF     = 12'h378,
  parameter int unsigned HI_BIT  = 10,
  parameter logic [3:0]  WIN_W   = 4'd8,
  parameter logic [3:0]  WIN_N   = 4'd4
) (
  input  logic [PBD_CW-1:0] cfg_i,
  input  logic              pd_i,
  input  logic              gate_i,
  input  logic              wide_req_i,
  input  logic              hi_req_i,
  output slot_t             slot_o,
  output logic [3:0]        win_o
);
  logic     wide_mode;
  logic     hi_mode;
  io_addr_t shifted;
  io_addr_t aligned;
  io_addr_t picked;
  io_addr_t hi_set;
  logic     out_of_range;

  always_comb begin
    wide_mode    = gate_i & wide_req_i;
    hi_mode      = gate_i & hi_req_i;
    shifted      = PBD_AW'(cfg_i) << SHIFT;
    aligned      = shifted & (wide_mode ? ALIGN_W : ALIGN_N);
    out_of_range = (aligned < LO) || (aligned > HI);
    picked       = out_of_range ? DEF : aligned;
    hi_set       = '0;
    hi_set[HI_BIT] = hi_mode;
    slot_o.base  = picked | hi_set;
    slot_o.en    = (|cfg_i[PBD_CW-1 -: 2]) & ~pd_i;
    win_o        = wide_mode ? WIN_W : WIN_N;
  end
endmodule

// File: rtl/periph_base_decoder.sv
module periph_base_decoder
  import pbd_pkg::*;
#(
  parameter io_addr_t    FDC_DEF    = 12'h3F0,
  parameter io_addr_t    PAR_DEF    = 12'h378,
  parameter io_addr_t    SER0_DEF   = 12'h3F8,
  parameter io_addr_t    SER1_DEF   = 12'h2F8,
  parameter io_addr_t    FLOOR      = 12'h100,
  parameter io_addr_t    FDC_CEIL   = 12'h3F0,
  parameter io_addr_t    SER_CEIL   = 12'h3F8,
  parameter io_addr_t    PAR_CEIL   = 12'h3FF,
  parameter int unsigned PD_PAR_BIT = 7,
  parameter int unsigned PD_S0_BIT  = 5,
  parameter int unsigned PD_S1_BIT  = 4,
  parameter int unsigned WIDE_BIT   = 2,
  parameter int unsigned HIMODE_BIT = 3,
  parameter int unsigned GATE_BIT   = 7,
  parameter int unsigned PAR_HI_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PBD_CW-1:0] fdc_cfg_i,
  input  logic [PBD_CW-1:0] par_cfg_i,
  input  logic [PBD_CW-1:0] ser0_cfg_i,
  input  logic [PBD_CW-1:0] ser1_cfg_i,
  input  logic [PBD_CW-1:0] pd_cfg_i,
  input  logic [PBD_CW-1:0] mode_cfg_i,
  input  logic [PBD_CW-1:0] ext_cfg_i,
  output logic [PBD_AW-1:0] fdc_base_o,
  output logic              fdc_en_o,
  output logic [PBD_AW-1:0] par_base_o,
  output logic [3:0]        par_win_o,
  output logic              par_en_o,
  output logic [PBD_AW-1:0] ser0_base_o,
  output logic              ser0_en_o,
  output logic [PBD_AW-1:0] ser1_base_o,
  output logic              ser1_en_o
);
  localparam int unsigned NSER = 2;
  localparam logic [3:0]  WIN_RST = 4'd4;

  logic rst_q_n;
  logic unused_cfg_bits;

  assign unused_cfg_bits = ^{pd_cfg_i, mode_cfg_i, ext_cfg_i};

  pbd_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // ---------------- combinational decode ----------------
  slot_t            fdc_d;
  slot_t            par_d;
  slot_t [NSER-1:0] ser_d;
  logic  [3:0]      win_d;
  logic  [NSER-1:0] ser_pd;
  logic  [PBD_CW-1:0] ser_cfg [NSER];

  assign ser_pd[0]  = pd_cfg_i[PD_S0_BIT];
  assign ser_pd[1]  = pd_cfg_i[PD_S1_BIT];
  assign ser_cfg[0] = ser0_cfg_i;
  assign ser_cfg[1] = ser1_cfg_i;

  pbd_slot_calc #(
    .KEEP (8'hFC), .SHIFT(2), .ALIGN(12'hFF0),
    .LO   (FLOOR), .HI(FDC_CEIL), .DEF(FDC_DEF)
  ) u_fdc (
    .cfg_i  (fdc_cfg_i),
    .pd_i   (1'b0),
    .slot_o (fdc_d)
  );

  for (genvar gi = 0; gi < NSER; gi++) begin : g_ser
    pbd_slot_calc #(
      .KEEP (8'hFE), .SHIFT(2), .ALIGN(12'hFF8),
      .LO   (FLOOR), .HI(SER_CEIL),
      .DEF  ((gi == 0) ? SER0_DEF : SER1_DEF)
    ) u_ser (
      .cfg_i  (ser_cfg[gi]),
      .pd_i   (ser_pd[gi]),
      .slot_o (ser_d[gi])
    );
  end

  pbd_par_calc #(
    .SHIFT(2), .ALIGN_W(12'h3F8), .ALIGN_N(12'h3FC),
    .LO(FLOOR), .HI(PAR_CEIL), .DEF(PAR_DEF), .HI_BIT(PAR_HI_BIT),
    .WIN_W(4'd8), .WIN_N(4'd4)
  ) u_par (
    .cfg_i      (par_cfg_i),
    .pd_i       (pd_cfg_i[PD_PAR_BIT]),
    .gate_i     (ext_cfg_i[GATE_BIT]),
    .wide_req_i (mode_cfg_i[WIDE_BIT]),
    .hi_req_i   (mode_cfg_i[HIMODE_BIT]),
    .slot_o     (par_d),
    .win_o      (win_d)
  );

  // ---------------- output register stage ----------------
  slot_t            fdc_q,  fdc_n;
  slot_t            par_q,  par_n;
  slot_t [NSER-1:0] ser_q,  ser_n;
  logic  [3:0]      win_q,  win_n;

  always_comb begin
    fdc_n = fdc_d;
    par_n = par_d;
    ser_n = ser_d;
    win_n = win_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      fdc_q <= '{base: FDC_DEF, en: 1'b0};
      par_q <= '{base: PAR_DEF, en: 1'b0};
      ser_q <= {slot_t'{base: SER1_DEF, en: 1'b0}, slot_t'{base: SER0_DEF, en: 1'b0}};
      win_q <= WIN_RST;
    end else begin
      fdc_q <= fdc_n;
      par_q <= par_n;
      ser_q <= ser_n;
      win_q <= win_n;
    end
  end

  assign fdc_base_o  = fdc_q.base;
  assign fdc_en_o    = fdc_q.en;
  assign par_base_o  = par_q.base;
  assign par_en_o    = par_q.en;
  assign par_win_o   = win_q;
  assign ser0_base_o = ser_q[0].base;
  assign ser0_en_o   = ser_q[0].en;
  assign ser1_base_o = ser_q[1].base;
  assign ser1_en_o   = ser_q[1].en;

  // ---------------- assertions ----------------
  a_r1_fdc_align: assert property (@(posedge clk) disable iff (!rst_q_n)
    fdc_base_o[3:0] == 4'h0);

  a_r2_fdc_window: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fdc_base_o >= FLOOR) && (fdc_base_o <= FDC_CEIL));

  a_r3_ser_window: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ser0_base_o[2:0] == 3'h0) && (ser1_base_o[2:0] == 3'h0) &&
    (ser0_base_o >= FLOOR) && (ser0_base_o <= SER_CEIL) &&
    (ser1_base_o >= FLOOR) && (ser1_base_o <= SER_CEIL));

  a_r4_wide_win: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ext_cfg_i[GATE_BIT] && mode_cfg_i[WIDE_BIT]) |=> (par_win_o == 4'd8));

  a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ext_cfg_i[GATE_BIT] |=> ((par_win_o == 4'd4) && !par_base_o[PAR_HI_BIT]));

  a_r7_hi_bit: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ext_cfg_i[GATE_BIT] && mode_cfg_i[HIMODE_BIT]) |=> par_base_o[PAR_HI_BIT]);

  a_r9_ser0_pd: assert property (@(posedge clk) disable iff (!rst_q_n)
    pd_cfg_i[PD_S0_BIT] |=> !ser0_en_o);

  a_r9_par_pd: assert property (@(posedge clk) disable iff (!rst_q_n)
    pd_cfg_i[PD_PAR_BIT] |=> !par_en_o);

  a_r8_fdc_en: assert property (@(posedge clk) disable iff (!rst_q_n)
    (fdc_cfg_i[7:6] == 2'b00) |=> !fdc_en_o);
endmodule

// File: tb/sim_periph_base_decoder.sv
module sim_periph_base_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  fdc_cfg, par_cfg, s0_cfg, s1_cfg, pd_cfg, md_cfg, ext_cfg;
  logic [11:0] fdc_base, par_base, s0_base, s1_base;
  logic [3:0]  par_win;
  logic        fdc_en, par_en, s0_en, s1_en;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  periph_base_decoder u0 (
    .clk(clk), .rst_n(rst_n),
    .fdc_cfg_i(fdc_cfg), .par_cfg_i(par_cfg), .ser0_cfg_i(s0_cfg),
    .ser1_cfg_i(s1_cfg), .pd_cfg_i(pd_cfg), .mode_cfg_i(md_cfg),
    .ext_cfg_i(ext_cfg),
    .fdc_base_o(fdc_base), .fdc_en_o(fdc_en),
    .par_base_o(par_base), .par_win_o(par_win), .par_en_o(par_en),
    .ser0_base_o(s0_base), .ser0_en_o(s0_en),
    .ser1_base_o(s1_base), .ser1_en_o(s1_en)
  );

  typedef struct packed {
    logic [7:0]  f, p, s0, s1, pd, md, ex;
    logic [11:0] ef, ep, es0, es1;
    logic [3:0]  ew;
    logic [3:0]  een; // {fdc, par, s0, s1}
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{8'hFC, 8'hDE, 8'hFE, 8'hBE, 8'h00, 8'h00, 8'h00, 12'h3F0, 12'h378, 12'h3F8, 12'h2F8, 4'd4, 4'b1111},
    '{8'h40, 8'hDF, 8'h41, 8'h41, 8'h00, 8'h04, 8'h80, 12'h100, 12'h378, 12'h100, 12'h100, 4'd8, 4'b1111},
    '{8'h3F, 8'hDF, 8'h3F, 8'h3F, 8'h00, 8'h08, 8'h80, 12'h3F0, 12'h77C, 12'h3F8, 12'h2F8, 4'd4, 4'b0100},
    '{8'hC1, 8'h3F, 8'hBF, 8'hFF, 8'h00, 8'h0C, 8'h80, 12'h300, 12'h778, 12'h2F8, 12'h3F8, 4'd8, 4'b1011},
    '{8'h7B, 8'hFF, 8'hFE, 8'hFE, 8'hB0, 8'h0C, 8'h00, 12'h1E0, 12'h3FC, 12'h3F8, 12'h3F8, 4'd4, 4'b1000},
    '{8'h80, 8'hDF, 8'h80, 8'h7F, 8'h40, 8'h04, 8'h00, 12'h200, 12'h37C, 12'h200, 12'h1F8, 4'd4, 4'b1111},
    '{8'h00, 8'h40, 8'h40, 8'h40, 8'h20, 8'h00, 8'h80, 12'h3F0, 12'h100, 12'h100, 12'h100, 4'd4, 4'b0101},
    '{8'h10, 8'hFF, 8'hC0, 8'hC0, 8'h10, 8'h04, 8'h80, 12'h3F0, 12'h3F8, 12'h300, 12'h300, 4'd8, 4'b0110},
    '{8'hFC, 8'hDE, 8'hFE, 8'hFE, 8'h80, 8'h08, 8'h80, 12'h3F0, 12'h778, 12'h3F8, 12'h3F8, 4'd4, 4'b1011}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    fdc_cfg = v.f; par_cfg = v.p; s0_cfg = v.s0; s1_cfg = v.s1;
    pd_cfg = v.pd; md_cfg = v.md; ext_cfg = v.ex;
  endtask

  task automatic chk_reset_state(input string tag);
    chk({tag, " R11 fdc base"},  fdc_base, 12'h3F0);
    chk({tag, " R11 par base"},  par_base, 12'h378);
    chk({tag, " R11 ser0 base"}, s0_base,  12'h3F8);
    chk({tag, " R11 ser1 base"}, s1_base,  12'h2F8);
    chk({tag, " R11 window"},    par_win,  4'd4);
    chk({tag, " R11 enables"},   {fdc_en, par_en, s0_en, s1_en}, 4'b0000);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    chk_reset_state("hold");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2 R3 R4 R5 R6 R7 R8 R9: vector table
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      chk("R1 R2 fdc base",       fdc_base, VECS[i].ef);
      chk("R4 R5 R7 par base",    par_base, VECS[i].ep);
      chk("R3 ser0 base",         s0_base,  VECS[i].es0);
      chk("R3 ser1 base",         s1_base,  VECS[i].es1);
      chk("R4 R6 par window",     par_win,  VECS[i].ew);
      chk("R8 R9 enables",        {fdc_en, par_en, s0_en, s1_en}, VECS[i].een);
    end

    // R10: change lands only after one rising edge
    fdc_cfg = 8'h40;
    #1;
    chk("R10 before edge", fdc_base, 12'h3F0);
    @(negedge clk);
    chk("R10 after edge", fdc_base, 12'h100);

    // R9: ignored power-down bit 6 keeps everything enabled
    drive(VECS[0]);
    pd_cfg = 8'h4F;
    @(negedge clk);
    chk("R9 ignored pd bits", {fdc_en, par_en, s0_en, s1_en}, 4'b1111);

    // R11: asynchronous assertion of reset
    #2 rst_n = 1'b0;
    #1;
    chk_reset_state("async");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 after re-release", fdc_base, 12'h3F0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule